// File: doc/BRIEF.md
# Test Response Compactor with Counters and Signatures

This block condenses the responses of a circuit under test into short summaries while a test runs. A single serial response bit feeds two saturating counters, one counting ones and one counting changes between consecutive bits, and a four-stage signature register that computes the remainder of the bit stream divided by 1 + x + x^4. A separate four-bit response word feeds a multiple-input signature register built on the same polynomial, so four response streams fold into one remainder.

Every summary advances only on cycles where the valid strobe is high, so the stream may pause at any point. Both signature registers follow exact polynomial-division order: the highest-degree coefficient enters first, and input lane i carries a stream weighted by x^i. That lets a known aliasing case be reproduced bit for bit. A golden-value compare and a pattern source sit outside this block.

Top module: `resp_compactor`

## Requirements
- R1: The ones count equals the number of valid cycles on which the serial bit was 1. The stream 01101111 gives 6 and 00110001 gives 3.
- R2: The transition count ignores the first valid bit after reset and then adds one for each valid bit that differs from the previous valid bit. The streams 01101111 and 00110001 both give 3.
- R3: Both counters are 4 bits wide and stop at 15 instead of wrapping. Twenty valid ones give a ones count of 15. Twenty alternating bits give a transition count of 15.
- R4: The serial signature is the remainder of the stream divided by 1 + x + x^4. Bits enter from the highest-degree coefficient down. Output bit i is the coefficient of x^i. A stream whose coefficients of x^0..x^7 are 1,0,0,1,1,0,1,1 gives coefficients 1,0,1,1 for x^0..x^3, which is output value 4'b1101.
- R5: The faulty stream 11111111 leaves the same serial signature as R4 (coefficients 1,0,1,1), so the fault aliases.
- R6: The parallel signature is the remainder of M0 + x·M1 + x^2·M2 + x^3·M3 divided by 1 + x + x^4. Here Mi is the stream on word bit i, and it enters highest-degree first. Streams with coefficients x^0..x^4 of 00010, 00010, 11100 and 10000 on bits 0..3 give coefficients 0,0,1,1, which is output value 4'b1100.
- R7: With word bits 1 to 3 held at 0, the parallel signature equals the serial signature of the stream on bit 0. The R4 stream gives 4'b1101.
- R8: On cycles with valid low, no count and no signature changes, whatever the data inputs do.
- R9: Asserting reset clears both counts and both signatures to zero. It also clears the record of any previous bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| valid_i | input | 1 | Response data valid this cycle |
| sbit_i | input | 1 | Serial response bit |
| pword_i | input | 4 | Parallel response word, bit i carries stream Mi |
| ones_cnt_o | output | 4 | Saturating count of ones |
| trans_cnt_o | output | 4 | Saturating count of bit changes |
| ssig_o | output | 4 | Serial signature, bit i = coefficient of x^i |
| psig_o | output | 4 | Parallel signature, bit i = coefficient of x^i |

## Verification
The bench reproduces the two aliasing cases exactly, which only a design with the correct bit order and feedback taps can do. With the entry order reversed or a tap misplaced, 11111111 would no longer match 10011011, and the four-stream case would not land on 0011. A design that counts the first bit as a transition would report 4 for 01101111 where 3 is expected. Counters that wrap would read 4 or 3 after the long runs rather than 15. Pauses with valid low and toggling data catch state that advances without the strobe.

// File: rtl/resp_compactor_pkg.sv
package resp_compactor_pkg;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned SIG_W = 4;
  // feedback taps: coefficients x^0..x^(SIG_W-1) of the divisor, x^SIG_W implied
  localparam logic [SIG_W-1:0] DIV_TAPS = 4'b0011;
  localparam int unsigned PAR_W = 4;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/resp_rst_sync.sv
module resp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/resp_ones_cnt.sv
module resp_ones_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         bit_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = '1;
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ld;

  always_comb begin
    cnt_ld = en && bit_i && (cnt_q != MAXV);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/resp_trans_cnt.sv
module resp_trans_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         bit_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = '1;
  logic [W-1:0] cnt_q, cnt_d;
  logic         prev_q, seen_q;
  logic         cnt_ld;

  always_comb begin
    cnt_ld = en && seen_q && (bit_i != prev_q) && (cnt_q != MAXV);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (en) begin
      prev_q <= bit_i;
      seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/resp_sig_reg.sv
module resp_sig_reg #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] TAPS = 4'b0011
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig_o
);
  logic [W-1:0] sig_q, sig_d;
  logic         fb;

  assign fb = sig_q[W-1];

  // one division step: multiply remainder by x, reduce, add the input word
  always_comb begin
    sig_d[0] = (TAPS[0] & fb) ^ din[0];
  end

  for (genvar i = 1; i < W; i++) begin : g_stage
    always_comb begin
      sig_d[i] = sig_q[i-1] ^ (TAPS[i] & fb) ^ din[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sig_q <= '0;
    else if (en) sig_q <= sig_d;
  end

  assign sig_o = sig_q;
endmodule

// File: rtl/resp_compactor.sv
module resp_compactor
  import resp_compactor_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             sbit_i,
  input  logic [PAR_W-1:0] pword_i,
  output logic [CNT_W-1:0] ones_cnt_o,
  output logic [CNT_W-1:0] trans_cnt_o,
  output logic [SIG_W-1:0] ssig_o,
  output logic [SIG_W-1:0] psig_o
);
  logic             rst_sync_n;
  logic [SIG_W-1:0] s_word;
  logic [SIG_W-1:0] p_word;

  resp_rst_sync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  resp_ones_cnt #(.W(CNT_W)) u_ones (
    .clk(clk), .rst_n(rst_sync_n), .en(valid_i), .bit_i(sbit_i), .cnt_o(ones_cnt_o)
  );

  resp_trans_cnt #(.W(CNT_W)) u_trans (
    .clk(clk), .rst_n(rst_sync_n), .en(valid_i), .bit_i(sbit_i), .cnt_o(trans_cnt_o)
  );

  // serial stream enters at the x^0 position only
  always_comb begin
    s_word    = '0;
    s_word[0] = sbit_i;
  end

  // lane i of the word is weighted by x^i
  always_comb begin
    p_word = '0;
    p_word[PAR_W-1:0] = pword_i;
  end

  resp_sig_reg #(.W(SIG_W), .TAPS(DIV_TAPS)) u_ssig (
    .clk(clk), .rst_n(rst_sync_n), .en(valid_i), .din(s_word), .sig_o(ssig_o)
  );

  resp_sig_reg #(.W(SIG_W), .TAPS(DIV_TAPS)) u_psig (
    .clk(clk), .rst_n(rst_sync_n), .en(valid_i), .din(p_word), .sig_o(psig_o)
  );
endmodule

// File: rtl/resp_compactor_sva.sv
module resp_compactor_sva
  import resp_compactor_pkg::*;
(
  input logic             clk,
  input logic             rst_sync_n,
  input logic             valid_i,
  input logic             sbit_i,
  input logic [PAR_W-1:0] pword_i,
  input logic [CNT_W-1:0] ones_cnt_o,
  input logic [CNT_W-1:0] trans_cnt_o,
  input logic [SIG_W-1:0] ssig_o,
  input logic [SIG_W-1:0] psig_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !valid_i |=> $stable(ones_cnt_o) && $stable(trans_cnt_o) && $stable(ssig_o) && $stable(psig_o)); // R8

  AST_ONES_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && sbit_i && ones_cnt_o != CMAX) |=> ones_cnt_o == $past(ones_cnt_o) + 1'b1); // R1

  AST_ONES_ZERO_BIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && !sbit_i) |=> $stable(ones_cnt_o)); // R1

  AST_ONES_SAT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ones_cnt_o == CMAX) |=> ones_cnt_o == CMAX); // R3

  AST_TRANS_SAT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trans_cnt_o == CMAX) |=> trans_cnt_o == CMAX); // R3

  AST_TRANS_NODROP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> trans_cnt_o >= $past(trans_cnt_o)); // R2

  AST_SSIG_ZERO_STAY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && ssig_o == '0 && !sbit_i) |=> ssig_o == '0); // R4

  AST_PSIG_ZERO_STAY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_i && psig_o == '0 && pword_i == '0) |=> psig_o == '0); // R6
endmodule

bind resp_compactor resp_compactor_sva u_sva (
  .clk(clk), .rst_sync_n(rst_sync_n), .valid_i(valid_i), .sbit_i(sbit_i),
  .pword_i(pword_i), .ones_cnt_o(ones_cnt_o), .trans_cnt_o(trans_cnt_o),
  .ssig_o(ssig_o), .psig_o(psig_o)
);

// File: tb/resp_compactor_test.sv
`timescale 1ns/1ps
module resp_compactor_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       valid_i;
  logic       sbit_i;
  logic [3:0] pword_i;
  logic [3:0] ones_cnt_o, trans_cnt_o, ssig_o, psig_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  resp_compactor uut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .sbit_i(sbit_i), .pword_i(pword_i),
    .ones_cnt_o(ones_cnt_o), .trans_cnt_o(trans_cnt_o), .ssig_o(ssig_o), .psig_o(psig_o)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid_i = 1'b0; sbit_i = 1'b0; pword_i = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // drives bits [0..n-1] of s, bit 0 first (rightmost written bit = highest degree)
  task automatic feed_serial(input logic [31:0] s, input int n);
    for (int i = 0; i < n; i++) begin
      valid_i = 1'b1; sbit_i = s[i]; pword_i = {3'b000, s[i]};
      @(negedge clk);
    end
    valid_i = 1'b0;
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 ones", ones_cnt_o, 4'd0);
    chk("R9 trans", trans_cnt_o, 4'd0);
    chk("R9 ssig", ssig_o, 4'd0);
    chk("R9 psig", psig_o, 4'd0);
    do_reset();
  endtask

  task automatic t_good_stream();
    do_reset();
    feed_serial(32'b10011011, 8);
    chk("R4 ssig good", ssig_o, 4'b1101);
    chk("R7 psig single lane", psig_o, 4'b1101);
  endtask

  task automatic t_faulty_stream();
    do_reset();
    feed_serial(32'b11111111, 8);
    chk("R5 ssig alias", ssig_o, 4'b1101);
    chk("R1 ones 11111111", ones_cnt_o, 4'd8);
  endtask

  task automatic t_counts_a();
    do_reset();
    feed_serial(32'b01101111, 8);
    chk("R1 ones 01101111", ones_cnt_o, 4'd6);
    chk("R2 trans 01101111", trans_cnt_o, 4'd3);
  endtask

  task automatic t_counts_b();
    do_reset();
    feed_serial(32'b00110001, 8);
    chk("R1 ones 00110001", ones_cnt_o, 4'd3);
    chk("R2 trans 00110001", trans_cnt_o, 4'd3);
  endtask

  task automatic t_first_bit();
    do_reset();
    feed_serial(32'b1, 1);
    chk("R2 first bit ignored", trans_cnt_o, 4'd0);
  endtask

  task automatic t_misr();
    logic [4:0] m0, m1, m2, m3;
    m0 = 5'b00010; m1 = 5'b00010; m2 = 5'b11100; m3 = 5'b10000;
    do_reset();
    for (int i = 0; i < 5; i++) begin
      valid_i = 1'b1; sbit_i = 1'b0;
      pword_i = {m3[i], m2[i], m1[i], m0[i]};
      @(negedge clk);
    end
    valid_i = 1'b0;
    chk("R6 psig four streams", psig_o, 4'b1100);
  endtask

  task automatic t_saturate();
    do_reset();
    feed_serial(32'hFFFFF, 20);
    chk("R3 ones saturate", ones_cnt_o, 4'd15);
    chk("R3 trans none", trans_cnt_o, 4'd0);
    do_reset();
    feed_serial(32'hAAAAA, 20);
    chk("R3 trans saturate", trans_cnt_o, 4'd15);
    chk("R1 ones alternating", ones_cnt_o, 4'd10);
  endtask

  task automatic t_idle();
    logic [3:0] o, t, s, p;
    do_reset();
    feed_serial(32'b0110, 4);
    o = ones_cnt_o; t = trans_cnt_o; s = ssig_o; p = psig_o;
    for (int i = 0; i < 6; i++) begin
      valid_i = 1'b0; sbit_i = i[0]; pword_i = 4'(i * 5);
      @(negedge clk);
    end
    chk("R8 ones held", ones_cnt_o, o);
    chk("R8 trans held", trans_cnt_o, t);
    chk("R8 ssig held", ssig_o, s);
    chk("R8 psig held", psig_o, p);
    // first valid bit after pause continues the history: prev 0, new 1 -> +1
    feed_serial(32'b1, 1);
    chk("R2 across pause", trans_cnt_o, t + 4'd1);
  endtask

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; sbit_i = 1'b0; pword_i = '0;
    t_reset_state();
    t_good_stream();
    t_faulty_stream();
    t_counts_a();
    t_counts_b();
    t_first_bit();
    t_misr();
    t_saturate();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule